// File: doc/BRIEF.md
# Read-Pattern Command Detector

This block watches the accesses on an ordinary asynchronous-style memory bus, after those accesses have been brought into a clock domain, and picks out a secret knock: six reads in a row from fixed addresses. The first five addresses are always the same. The sixth address chooses one of four commands: save the array to nonvolatile storage, restore it, inhibit the automatic save, or lift that inhibit. When the pattern completes, the block raises one single-cycle pulse toward the save/restore sequencer.

The detector only observes the bus. Normal reads and writes go through untouched. Some events cancel progress through the pattern: a write, a read of any other address, a busy sequencer, or a low supply. A bus access with both output enable and write enable high is not a read, and it leaves progress as it was.

Top module: `seqcmd_detect`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, all four command outputs are low and pattern progress is empty.
- R2: A read is an access event (`acc_evt` high for one cycle) with `we_n`=1 and `oe_n`=0. Five reads at 16'h4E38, 16'hB1C7, 16'h83E0, 16'h7C1F and 16'h703F, followed by a read at 16'h8FC0, raise `cmd_save` for exactly one cycle, in the cycle after the sixth access event.
- R3: The same five-read prefix followed by a read at 16'h4C63 pulses `cmd_restore` in the same way.
- R4: The prefix followed by 16'h8B45 pulses `cmd_inhibit`, and the prefix followed by 16'h4B46 pulses `cmd_uninhibit`.
- R5: Matching uses only `addr[15:0]`. Higher address bits have no effect on the result.
- R6: An access event with `we_n`=0 clears progress. A complete pattern that has a write anywhere inside it issues no command.
- R7: A read of a wrong address clears progress. If that read is at 16'h4E38, it counts as the first step of a new pattern, so five more correct reads complete a command.
- R8: An access event with `we_n`=1 and `oe_n`=1 neither advances nor clears progress. Cycles without an access event also leave progress unchanged.
- R9: While `seq_busy` or `pwr_low` is high, progress is cleared and no read advances it. No command is issued.
- R10: At most one command output is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_evt | input | 1 | One-cycle pulse marking a completed bus access |
| we_n | input | 1 | Write enable of that access, active low |
| oe_n | input | 1 | Output enable of that access, active low |
| addr | input | ADDR_W | Address of that access |
| seq_busy | input | 1 | Save/restore sequencer is busy |
| pwr_low | input | 1 | Supply is below the threshold |
| cmd_save | output | 1 | Save command pulse |
| cmd_restore | output | 1 | Restore command pulse |
| cmd_inhibit | output | 1 | Autosave-inhibit command pulse |
| cmd_uninhibit | output | 1 | Autosave-inhibit-off command pulse |

## Verification
The block's only hidden state is how far it has progressed through the pattern. If that progress is wrong, the ports show it at the end of a pattern: a command pulse appears where none should, or a pattern ends without its pulse. Either way the error is visible one cycle after the sixth access event. Patterns that abort part-way and then restart are included so that a stale or wrongly reset step count also shows up at that cycle.

// File: rtl/seqcmd_detect.sv
module seqcmd_detect #(
  parameter int ADDR_W = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_evt,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              seq_busy,
  input  logic              pwr_low,
  output logic              cmd_save,
  output logic              cmd_restore,
  output logic              cmd_inhibit,
  output logic              cmd_uninhibit
);

  localparam int KEY_W   = 16;
  localparam int PREFIX  = 5;
  localparam int STEP_W  = $clog2(PREFIX + 1);

  localparam logic [KEY_W-1:0] OP_SAVE   = 16'h8FC0;
  localparam logic [KEY_W-1:0] OP_REST   = 16'h4C63;
  localparam logic [KEY_W-1:0] OP_INH    = 16'h8B45;
  localparam logic [KEY_W-1:0] OP_UNINH  = 16'h4B46;

  function automatic logic [KEY_W-1:0] key_at(input logic [STEP_W-1:0] idx);
    case (idx)
      3'd0:    key_at = 16'h4E38;
      3'd1:    key_at = 16'hB1C7;
      3'd2:    key_at = 16'h83E0;
      3'd3:    key_at = 16'h7C1F;
      default: key_at = 16'h703F;
    endcase
  endfunction

  logic [STEP_W-1:0] step, step_nxt;
  logic [KEY_W-1:0]  a16;
  logic              blocked, is_write, is_read, at_op;
  logic              hit_key, hit_first;
  logic [3:0]        cmd_nxt;

  assign a16       = addr[KEY_W-1:0];
  assign blocked   = seq_busy | pwr_low;
  assign is_write  = acc_evt & ~we_n;
  assign is_read   = acc_evt & we_n & ~oe_n;
  assign at_op     = (step == STEP_W'(PREFIX));
  assign hit_key   = (a16 == key_at(step));
  assign hit_first = (a16 == key_at('0));

  always_comb begin
    step_nxt = step;
    cmd_nxt  = '0;
    if (blocked || is_write) begin
      step_nxt = '0;
    end else if (is_read) begin
      if (at_op) begin
        cmd_nxt  = {a16 == OP_UNINH, a16 == OP_INH, a16 == OP_REST, a16 == OP_SAVE};
        step_nxt = (cmd_nxt == '0 && hit_first) ? STEP_W'(1) : '0;
      end else if (hit_key) begin
        step_nxt = step + STEP_W'(1);
      end else begin
        step_nxt = hit_first ? STEP_W'(1) : '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      step <= '0;
      {cmd_uninhibit, cmd_inhibit, cmd_restore, cmd_save} <= '0;
    end else begin
      step <= step_nxt;
      {cmd_uninhibit, cmd_inhibit, cmd_restore, cmd_save} <= cmd_nxt;
    end
  end

endmodule

// File: rtl/seqcmd_detect_chk.sv
module seqcmd_detect_chk #(
  parameter int ADDR_W = 17
) (
  input logic              clk,
  input logic              rst_n,
  input logic              acc_evt,
  input logic              we_n,
  input logic              oe_n,
  input logic [ADDR_W-1:0] addr,
  input logic              seq_busy,
  input logic              pwr_low,
  input logic              cmd_save,
  input logic              cmd_restore,
  input logic              cmd_inhibit,
  input logic              cmd_uninhibit
);

  logic any_cmd;
  assign any_cmd = cmd_save | cmd_restore | cmd_inhibit | cmd_uninhibit;

  p_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cmd_save, cmd_restore, cmd_inhibit, cmd_uninhibit}));

  p_single_cycle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    any_cmd |=> !any_cmd);

  p_from_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
    any_cmd |-> $past(acc_evt && we_n && !oe_n));

  p_not_blocked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    any_cmd |-> $past(!seq_busy && !pwr_low));

  p_save_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_save |-> $past(addr[15:0]) == 16'h8FC0);

  p_restore_addr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_restore |-> $past(addr[15:0]) == 16'h4C63);

  p_inh_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_inhibit |-> $past(addr[15:0]) == 16'h8B45) and
    (cmd_uninhibit |-> $past(addr[15:0]) == 16'h4B46));

endmodule

bind seqcmd_detect seqcmd_detect_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/seqcmd_detect_bench.sv
module seqcmd_detect_bench;
  localparam int AW = 17;

  logic clk = 0, rst_n = 0;
  logic acc_evt = 0, we_n = 1, oe_n = 1, seq_busy = 0, pwr_low = 0;
  logic [AW-1:0] addr = '0;
  logic cmd_save, cmd_restore, cmd_inhibit, cmd_uninhibit;

  always #2.5 clk = ~clk;

  seqcmd_detect #(.ADDR_W(AW)) u_seqcmd_detect (
    .clk(clk), .rst_n(rst_n), .acc_evt(acc_evt), .we_n(we_n), .oe_n(oe_n),
    .addr(addr), .seq_busy(seq_busy), .pwr_low(pwr_low),
    .cmd_save(cmd_save), .cmd_restore(cmd_restore),
    .cmd_inhibit(cmd_inhibit), .cmd_uninhibit(cmd_uninhibit));

  int n_run = 0, n_fail = 0;
  string cur_req = "R1";
  logic [15:0] prefix [$] = '{16'h4E38, 16'hB1C7, 16'h83E0, 16'h7C1F, 16'h703F};
  int pos = 0;
  logic [3:0] exp_cmd = '0;
  int seen [4] = '{0, 0, 0, 0};

  always @(posedge clk) begin
    exp_cmd = '0;
    if (!rst_n || seq_busy || pwr_low) pos = 0;
    else if (acc_evt && !we_n) pos = 0;
    else if (acc_evt && !oe_n) begin
      if (pos == 5) begin
        case (addr[15:0])
          16'h8FC0: exp_cmd = 4'b0001;
          16'h4C63: exp_cmd = 4'b0010;
          16'h8B45: exp_cmd = 4'b0100;
          16'h4B46: exp_cmd = 4'b1000;
          default: ;
        endcase
        pos = (exp_cmd == 0 && addr[15:0] == prefix[0]) ? 1 : 0;
      end else if (addr[15:0] == prefix[pos]) pos++;
      else pos = (addr[15:0] == prefix[0]) ? 1 : 0;
    end
  end

  always @(negedge clk) begin
    logic [3:0] got;
    got = {cmd_uninhibit, cmd_inhibit, cmd_restore, cmd_save};
    for (int i = 0; i < 4; i++) if (got[i]) seen[i]++;
    n_run++;
    if (got !== exp_cmd) begin
      n_fail++;
      $display("FAIL %s: cmd=%b expected %b at %0t", cur_req, got, exp_cmd, $time);
    end
  end

  task automatic acc(input logic [AW-1:0] a, input logic w, input logic o);
    addr = a; we_n = w; oe_n = o; acc_evt = 1;
    @(negedge clk);
    acc_evt = 0; we_n = 1; oe_n = 1;
    @(negedge clk);
  endtask

  task automatic rd(input logic [AW-1:0] a);
    acc(a, 1'b1, 1'b0);
  endtask

  task automatic pre(input int upto);
    for (int i = 0; i < upto; i++) rd({1'b0, prefix[i]});
  endtask

  task automatic expect_seen(input string req, input int idx, input int want);
    n_run++;
    if (seen[idx] != want) begin
      n_fail++;
      $display("FAIL %s: pulse count[%0d]=%0d expected %0d", req, idx, seen[idx], want);
    end
  endtask

  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog: run did not finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    cur_req = "R1";
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    cur_req = "R2"; pre(5); rd(17'h08FC0); expect_seen("R2", 0, 1);
    cur_req = "R3"; pre(5); rd(17'h04C63); expect_seen("R3", 1, 1);
    cur_req = "R4"; pre(5); rd(17'h08B45); pre(5); rd(17'h04B46);
    expect_seen("R4", 2, 1); expect_seen("R4", 3, 1);
    cur_req = "R5"; rd(17'h14E38); rd(17'h1B1C7); pre(5); rd(17'h18FC0);
    expect_seen("R5", 0, 2);
    cur_req = "R6"; pre(3); acc(17'h083E0, 1'b0, 1'b1); pre(5);
    acc(17'h08FC0, 1'b0, 1'b0); rd(17'h08FC0); expect_seen("R6", 0, 2);
    cur_req = "R7"; pre(2); rd(17'h01234); rd(17'h0B1C7); rd(17'h083E0);
    rd(17'h07C1F); rd(17'h0703F); rd(17'h04C63); expect_seen("R7", 1, 1);
    pre(3); rd(17'h04E38); rd(17'h0B1C7); rd(17'h083E0); rd(17'h07C1F);
    rd(17'h0703F); rd(17'h04C63); expect_seen("R7", 1, 2);
    pre(5); rd(17'h04E38); rd(17'h0B1C7); rd(17'h083E0); rd(17'h07C1F);
    rd(17'h0703F); rd(17'h08B45); expect_seen("R7", 2, 2);
    cur_req = "R8"; pre(2); acc(17'h05555, 1'b1, 1'b1); repeat (4) @(negedge clk);
    rd(17'h083E0); rd(17'h07C1F); rd(17'h0703F); rd(17'h08FC0);
    expect_seen("R8", 0, 3);
    cur_req = "R9"; pre(3); seq_busy = 1; @(negedge clk); seq_busy = 0;
    rd(17'h07C1F); rd(17'h0703F); rd(17'h08FC0); expect_seen("R9", 0, 3);
    pwr_low = 1; pre(5); rd(17'h08FC0); pwr_low = 0; expect_seen("R9", 0, 3);
    cur_req = "R10"; pre(5); rd(17'h0ABCD); rd(17'h08FC0);
    expect_seen("R10", 0, 3);
    cur_req = "R1"; pre(4); rst_n = 0; @(negedge clk); rst_n = 1;
    rd(17'h0703F); rd(17'h04C63); expect_seen("R1", 1, 2);
    repeat (3) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule